// File: doc/BRIEF.md
# Accumulator Instruction Execute Unit

This block carries out one already-decoded instruction at a time for a machine with 40-bit words. It holds two architectural registers: the accumulator (AC) and a multiplier/quotient register (MQ). The fetch stage hands it an 8-bit opcode and a 12-bit operand address X. The unit then reads or writes memory over a single-port request interface and, for branches, reports the target back to fetch. When the instruction finishes it pulses `done`. Memory is not touched for register-only operations or branches.

Numbers are two's complement, with the sign in bit 39 of the word vector. An instruction word packs two 20-bit halves. Each half holds an 8-bit opcode followed by a 12-bit address. The left half's address field therefore sits in word bits [31:20] and the right half's in bits [11:0].

Multiply runs as a 40-step shift-and-add on magnitudes and divide as a 40-step restoring loop, each with a sign fix at the end. An address-modify store is a read-modify-write of one word.

Top module: `acc_exec_unit`

## Requirements
- R1: After reset, AC and MQ are zero, `ready` is high, and `done`, `illegal_op`, `div_zero`, `br_valid` and `mem_req` are low.
- R2: Memory protocol and timing are fixed. An instruction is accepted on a clock edge where `issue_valid` and `ready` are both high. A read holds `mem_req` high with `mem_we` low for one cycle, and `mem_rdata` is used in the following cycle. `done` is a one-cycle pulse whose edge count from the issue edge is: 1 for register-only, branch and unknown opcodes; 2 for a plain store; 3 for memory-operand loads and add/sub; 4 for address-modify stores; 44 for multiply and divide.
- R3: Opcode 0x01 loads M(X) into AC. Opcode 0x02 loads −M(X), 0x03 loads |M(X)| and 0x04 loads −|M(X)|.
- R4: Opcode 0x09 loads M(X) into MQ. Opcode 0x0A copies MQ into AC. Opcode 0x21 writes AC to M(X).
- R5: Opcode 0x05 adds M(X) to AC and 0x07 adds |M(X)|. Opcode 0x06 subtracts M(X) and 0x08 subtracts |M(X)|. All four results go to AC, modulo 2^40.
- R6: Opcode 0x0B forms the signed 80-bit product of M(X) and MQ. The upper 40 bits go to AC and the lower 40 bits to MQ.
- R7: Opcode 0x0C divides AC by M(X) as signed numbers. The quotient, truncated toward zero, goes to MQ. The remainder, which takes the sign of the dividend, goes to AC.
- R8: A divide whose divisor is zero leaves AC and MQ unchanged and pulses `div_zero` together with `done`.
- R9: Opcode 0x14 shifts AC left one bit. Opcode 0x15 shifts AC right one bit arithmetically, so the sign is kept.
- R10: Opcodes 0x0D and 0x0E always redirect. They pulse `br_valid` with `done`, with `br_addr` = X and `br_right` low for 0x0D and high for 0x0E.
- R11: Opcodes 0x0F (left half) and 0x10 (right half) redirect only when AC bit 39 is 0. Otherwise they finish with `br_valid` low.
- R12: Opcode 0x12 replaces word bits [31:20] of M(X) with AC[11:0]. Opcode 0x13 replaces bits [11:0]. All other bits of the word are kept.
- R13: Any other opcode finishes in one edge, pulses `illegal_op` with `done`, and changes neither AC, MQ nor memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction offered by fetch |
| issue_opcode | input | 8 | Opcode of the offered instruction |
| issue_addr | input | 12 | Operand address X |
| ready | output | 1 | Unit idle, instruction can be accepted |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 12 | Word address of the access |
| mem_wdata | output | 40 | Write data |
| mem_rdata | input | 40 | Read data, valid the cycle after a read request |
| done | output | 1 | Instruction finished (one-cycle pulse) |
| illegal_op | output | 1 | Unknown opcode finished |
| div_zero | output | 1 | Divide by zero finished |
| br_valid | output | 1 | Redirect fetch |
| br_addr | output | 12 | Redirect word address |
| br_right | output | 1 | Redirect to right half of the word |
| ac_out | output | 40 | Current accumulator |
| mq_out | output | 40 | Current MQ register |

## Verification
A wrong sequencer state shows up first as a `done` pulse on the wrong edge, or as a `mem_req` in a cycle where none is due. The bench therefore checks each instruction's latency exactly. A fault in the shift-add or restoring loop stays hidden for the 40 step cycles and then shows as a wrong AC/MQ pair on the `done` edge. Operands with mixed signs and non-zero upper product bits expose sign-fix and carry faults. A wrong merge in an address-modify store shows as soon as the memory word is read back after `done`.

// File: rtl/acc_pkg.sv
package acc_pkg;
    localparam int WORD_W = 40;
    localparam int ADDR_W = 12;
    localparam int OPC_W  = 8;
    localparam int STEPS  = WORD_W;
    localparam int LFT_LSB = WORD_W - OPC_W - ADDR_W;

    localparam logic [OPC_W-1:0] OPC_LD   = 8'h01;
    localparam logic [OPC_W-1:0] OPC_LDN  = 8'h02;
    localparam logic [OPC_W-1:0] OPC_LDA  = 8'h03;
    localparam logic [OPC_W-1:0] OPC_LDNA = 8'h04;
    localparam logic [OPC_W-1:0] OPC_ADD  = 8'h05;
    localparam logic [OPC_W-1:0] OPC_SUB  = 8'h06;
    localparam logic [OPC_W-1:0] OPC_ADDA = 8'h07;
    localparam logic [OPC_W-1:0] OPC_SUBA = 8'h08;
    localparam logic [OPC_W-1:0] OPC_LDMQ = 8'h09;
    localparam logic [OPC_W-1:0] OPC_MQAC = 8'h0A;
    localparam logic [OPC_W-1:0] OPC_MUL  = 8'h0B;
    localparam logic [OPC_W-1:0] OPC_DIV  = 8'h0C;
    localparam logic [OPC_W-1:0] OPC_JL   = 8'h0D;
    localparam logic [OPC_W-1:0] OPC_JR   = 8'h0E;
    localparam logic [OPC_W-1:0] OPC_JPL  = 8'h0F;
    localparam logic [OPC_W-1:0] OPC_JPR  = 8'h10;
    localparam logic [OPC_W-1:0] OPC_PTL  = 8'h12;
    localparam logic [OPC_W-1:0] OPC_PTR  = 8'h13;
    localparam logic [OPC_W-1:0] OPC_SHL  = 8'h14;
    localparam logic [OPC_W-1:0] OPC_SHR  = 8'h15;
    localparam logic [OPC_W-1:0] OPC_ST   = 8'h21;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        K_ILL, K_REG, K_JUMP, K_READ, K_STORE, K_PATCH, K_MULDIV
    } op_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_READ, ST_EXEC, ST_WRITE, ST_MULDIV
    } xstate_t;

    typedef struct packed {
        word_t ac;
        word_t mq;
        word_t wword;
    } alu_res_t;

    function automatic op_kind_t op_kind(input logic [OPC_W-1:0] opc);
        case (opc)
            OPC_MQAC, OPC_SHL, OPC_SHR:            return K_REG;
            OPC_JL, OPC_JR, OPC_JPL, OPC_JPR:      return K_JUMP;
            OPC_LD, OPC_LDN, OPC_LDA, OPC_LDNA,
            OPC_ADD, OPC_SUB, OPC_ADDA, OPC_SUBA,
            OPC_LDMQ:                              return K_READ;
            OPC_ST:                                return K_STORE;
            OPC_PTL, OPC_PTR:                      return K_PATCH;
            OPC_MUL, OPC_DIV:                      return K_MULDIV;
            default:                               return K_ILL;
        endcase
    endfunction

    function automatic word_t mag(input word_t v);
        return v[WORD_W-1] ? word_t'(-v) : v;
    endfunction
endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    input  word_t            ac,
    input  word_t            mq,
    input  word_t            mdat,
    output alu_res_t         res
);
    word_t mabs;
    assign mabs = mag(mdat);

    always_comb begin
        res.ac    = ac;
        res.mq    = mq;
        res.wword = mdat;
        case (opc)
            OPC_LD:   res.ac = mdat;
            OPC_LDN:  res.ac = word_t'(-mdat);
            OPC_LDA:  res.ac = mabs;
            OPC_LDNA: res.ac = word_t'(-mabs);
            OPC_ADD:  res.ac = ac + mdat;
            OPC_ADDA: res.ac = ac + mabs;
            OPC_SUB:  res.ac = ac - mdat;
            OPC_SUBA: res.ac = ac - mabs;
            OPC_LDMQ: res.mq = mdat;
            OPC_MQAC: res.ac = mq;
            OPC_SHL:  res.ac = {ac[WORD_W-2:0], 1'b0};
            OPC_SHR:  res.ac = {ac[WORD_W-1], ac[WORD_W-1:1]};
            OPC_PTL:  res.wword[LFT_LSB +: ADDR_W] = ac[ADDR_W-1:0];
            OPC_PTR:  res.wword[0 +: ADDR_W] = ac[ADDR_W-1:0];
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_muldiv.sv
module acc_muldiv
    import acc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  is_div,
    input  word_t opa,
    input  word_t opb,
    output logic  busy,
    output logic  fin,
    output word_t res_hi,
    output word_t res_lo
);
    localparam int CW = $clog2(STEPS + 1);

    logic [WORD_W:0]   part;
    word_t             shf, magb;
    logic [CW-1:0]     cnt;
    logic              run, div_q, neg_q, rneg_q;
    logic [WORD_W:0]   msum, dsh, dtrial;
    logic [2*WORD_W-1:0] prod;
    word_t             rem_m;

    assign busy = run;
    assign fin  = run && (cnt == CW'(STEPS));

    assign msum   = part + (shf[0] ? {1'b0, magb} : '0);
    assign dsh    = {part[WORD_W-1:0], shf[WORD_W-1]};
    assign dtrial = dsh - {1'b0, magb};

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0; cnt <= '0; part <= '0; shf <= '0; magb <= '0;
            div_q <= 1'b0; neg_q <= 1'b0; rneg_q <= 1'b0;
        end else if (start) begin
            run    <= 1'b1;
            cnt    <= '0;
            div_q  <= is_div;
            part   <= '0;
            neg_q  <= opa[WORD_W-1] ^ opb[WORD_W-1];
            rneg_q <= opa[WORD_W-1];
            if (is_div) begin
                shf  <= mag(opa);
                magb <= mag(opb);
            end else begin
                shf  <= mag(opb);
                magb <= mag(opa);
            end
        end else if (run) begin
            if (fin) begin
                run <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
                if (div_q) begin
                    if (!dtrial[WORD_W]) begin
                        part <= dtrial;
                        shf  <= {shf[WORD_W-2:0], 1'b1};
                    end else begin
                        part <= dsh;
                        shf  <= {shf[WORD_W-2:0], 1'b0};
                    end
                end else begin
                    {part, shf} <= {1'b0, msum, shf[WORD_W-1:1]};
                end
            end
        end
    end

    always_comb begin
        prod  = {part[WORD_W-1:0], shf};
        rem_m = part[WORD_W-1:0];
        if (div_q) begin
            res_hi = rneg_q ? word_t'(-rem_m) : rem_m;
            res_lo = neg_q ? word_t'(-shf) : shf;
        end else begin
            if (neg_q) prod = -prod;
            res_hi = prod[2*WORD_W-1:WORD_W];
            res_lo = prod[WORD_W-1:0];
        end
    end

    p_fin_single_r6: assert property (@(posedge clk) disable iff (rst)
        fin |=> !fin);
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> cnt <= CW'(STEPS));
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
    import acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    input  logic [OPC_W-1:0]  issue_opcode,
    input  logic [ADDR_W-1:0] issue_addr,
    output logic              ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              done,
    output logic              illegal_op,
    output logic              div_zero,
    output logic              br_valid,
    output logic [ADDR_W-1:0] br_addr,
    output logic              br_right,
    output logic [WORD_W-1:0] ac_out,
    output logic [WORD_W-1:0] mq_out
);
    xstate_t           state;
    logic [OPC_W-1:0]  op_q, alu_op;
    logic [ADDR_W-1:0] addr_q;
    word_t             ac_q, mq_q, wbuf_q;
    logic              done_q, ill_q, dz_q, br_q, brr_q;
    op_kind_t          new_kind, cur_kind;
    alu_res_t          alu_r;
    logic              md_start, md_busy, md_fin, is_div, zero_div;
    word_t             md_hi, md_lo, md_a, md_b;

    assign new_kind = op_kind(issue_opcode);
    assign cur_kind = op_kind(op_q);
    assign alu_op   = (state == ST_IDLE) ? issue_opcode : op_q;
    assign is_div   = (op_q == OPC_DIV);
    assign zero_div = is_div && (mem_rdata == '0);
    assign md_start = (state == ST_EXEC) && (cur_kind == K_MULDIV) && !zero_div;
    assign md_a     = is_div ? ac_q : mem_rdata;
    assign md_b     = is_div ? mem_rdata : mq_q;

    acc_alu u_alu (
        .opc(alu_op), .ac(ac_q), .mq(mq_q), .mdat(mem_rdata), .res(alu_r)
    );

    acc_muldiv u_md (
        .clk(clk), .rst(rst), .start(md_start), .is_div(is_div),
        .opa(md_a), .opb(md_b), .busy(md_busy), .fin(md_fin),
        .res_hi(md_hi), .res_lo(md_lo)
    );

    assign ready      = (state == ST_IDLE);
    assign mem_req    = (state == ST_READ) || (state == ST_WRITE);
    assign mem_we     = (state == ST_WRITE);
    assign mem_addr   = addr_q;
    assign mem_wdata  = wbuf_q;
    assign done       = done_q;
    assign illegal_op = ill_q;
    assign div_zero   = dz_q;
    assign br_valid   = br_q;
    assign br_addr    = addr_q;
    assign br_right   = brr_q;
    assign ac_out     = ac_q;
    assign mq_out     = mq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE; op_q <= '0; addr_q <= '0;
            ac_q <= '0; mq_q <= '0; wbuf_q <= '0;
            done_q <= 1'b0; ill_q <= 1'b0; dz_q <= 1'b0; br_q <= 1'b0; brr_q <= 1'b0;
        end else begin
            done_q <= 1'b0; ill_q <= 1'b0; dz_q <= 1'b0; br_q <= 1'b0;
            case (state)
                ST_IDLE: if (issue_valid) begin
                    op_q   <= issue_opcode;
                    addr_q <= issue_addr;
                    case (new_kind)
                        K_REG: begin
                            ac_q <= alu_r.ac; mq_q <= alu_r.mq; done_q <= 1'b1;
                        end
                        K_JUMP: begin
                            done_q <= 1'b1;
                            brr_q  <= (issue_opcode == OPC_JR) || (issue_opcode == OPC_JPR);
                            br_q   <= (issue_opcode == OPC_JL) || (issue_opcode == OPC_JR)
                                      || !ac_q[WORD_W-1];
                        end
                        K_STORE: begin
                            wbuf_q <= ac_q; state <= ST_WRITE;
                        end
                        K_ILL: begin
                            ill_q <= 1'b1; done_q <= 1'b1;
                        end
                        default: state <= ST_READ;
                    endcase
                end
                ST_READ: state <= ST_EXEC;
                ST_EXEC: begin
                    case (cur_kind)
                        K_PATCH: begin
                            wbuf_q <= alu_r.wword; state <= ST_WRITE;
                        end
                        K_MULDIV: begin
                            if (zero_div) begin
                                dz_q <= 1'b1; done_q <= 1'b1; state <= ST_IDLE;
                            end else begin
                                state <= ST_MULDIV;
                            end
                        end
                        default: begin
                            ac_q <= alu_r.ac; mq_q <= alu_r.mq;
                            done_q <= 1'b1; state <= ST_IDLE;
                        end
                    endcase
                end
                ST_WRITE: begin
                    done_q <= 1'b1; state <= ST_IDLE;
                end
                ST_MULDIV: if (md_fin) begin
                    ac_q <= md_hi; mq_q <= md_lo; done_q <= 1'b1; state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_illegal_quiet_r13: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> done && $stable(ac_out) && $stable(mq_out));
    p_divzero_keep_r8: assert property (@(posedge clk) disable iff (rst)
        div_zero |-> done && $stable(ac_out) && $stable(mq_out));
    p_jump_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        br_valid |-> done && $stable(ac_out) && !mem_req);
    p_busy_no_issue_r2: assert property (@(posedge clk) disable iff (rst)
        md_busy |-> !ready && !mem_req);
endmodule

// File: tb/tb_acc_exec_unit.sv
`timescale 1ns/1ps
module tb_acc_exec_unit;
    import acc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        issue_valid = 1'b0;
    logic [7:0]  issue_opcode = '0;
    logic [11:0] issue_addr = '0;
    logic        ready, mem_req, mem_we, done, illegal_op, div_zero, br_valid, br_right;
    logic [11:0] mem_addr, br_addr;
    logic [39:0] mem_wdata, ac_out, mq_out;
    logic [39:0] rd_q = '0;

    acc_exec_unit dut (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_opcode(issue_opcode),
        .issue_addr(issue_addr), .ready(ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(rd_q), .done(done),
        .illegal_op(illegal_op), .div_zero(div_zero), .br_valid(br_valid),
        .br_addr(br_addr), .br_right(br_right), .ac_out(ac_out), .mq_out(mq_out)
    );

    logic [39:0] mem [64];
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
            else        rd_q <= mem[mem_addr[5:0]];
        end
    end

    int nvec = 0;
    int nbad = 0;
    logic signed [39:0] m_ac = '0;
    logic signed [39:0] m_mq = '0;

    task automatic chk(string tag, string what, logic [79:0] act, logic [79:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic run(logic [7:0] op, logic [11:0] x, string tag);
        logic signed [39:0] mv, e_ac, e_mq, am;
        logic signed [79:0] p;
        logic [39:0] e_word;
        int e_lat, lat;
        logic e_ill, e_dz, e_br, e_rt, mem_chk;
        mv = mem[x[5:0]];
        am = mv[39] ? -mv : mv;
        e_ac = m_ac; e_mq = m_mq; e_word = mv;
        e_ill = 0; e_dz = 0; e_br = 0; e_rt = 0; mem_chk = 0; e_lat = 3;
        case (op)
            8'h01: e_ac = mv;
            8'h02: e_ac = -mv;
            8'h03: e_ac = am;
            8'h04: e_ac = -am;
            8'h05: e_ac = m_ac + mv;
            8'h07: e_ac = m_ac + am;
            8'h06: e_ac = m_ac - mv;
            8'h08: e_ac = m_ac - am;
            8'h09: e_mq = mv;
            8'h0A: begin e_ac = m_mq; e_lat = 1; end
            8'h21: begin e_word = m_ac; mem_chk = 1; e_lat = 2; end
            8'h14: begin e_ac = m_ac <<< 1; e_lat = 1; end
            8'h15: begin e_ac = m_ac >>> 1; e_lat = 1; end
            8'h0B: begin
                p = $signed({{40{mv[39]}}, mv}) * $signed({{40{m_mq[39]}}, m_mq});
                e_ac = p[79:40]; e_mq = p[39:0]; e_lat = 44;
            end
            8'h0C: begin
                if (mv == 0) e_dz = 1;
                else begin e_mq = m_ac / mv; e_ac = m_ac % mv; e_lat = 44; end
            end
            8'h0D: begin e_br = 1; e_lat = 1; end
            8'h0E: begin e_br = 1; e_rt = 1; e_lat = 1; end
            8'h0F: begin e_br = (m_ac >= 0); e_lat = 1; end
            8'h10: begin e_br = (m_ac >= 0); e_rt = 1; e_lat = 1; end
            8'h12: begin e_word[31:20] = m_ac[11:0]; mem_chk = 1; e_lat = 4; end
            8'h13: begin e_word[11:0] = m_ac[11:0]; mem_chk = 1; e_lat = 4; end
            default: begin e_ill = 1; e_lat = 1; mem_chk = 1; end
        endcase
        chk(tag, "ready before issue", {79'd0, ready}, 80'd1);
        issue_valid = 1; issue_opcode = op; issue_addr = x;
        @(negedge clk);
        issue_valid = 0;
        lat = 1;
        while (!done && lat < 200) begin @(negedge clk); lat++; end
        chk(tag, "latency", 80'(lat), 80'(e_lat));
        chk(tag, "AC", {40'd0, ac_out}, {40'd0, e_ac});
        chk(tag, "MQ", {40'd0, mq_out}, {40'd0, e_mq});
        chk(tag, "illegal flag", {79'd0, illegal_op}, {79'd0, e_ill});
        chk(tag, "div-zero flag", {79'd0, div_zero}, {79'd0, e_dz});
        chk(tag, "redirect", {79'd0, br_valid}, {79'd0, e_br});
        if (e_br) chk(tag, "redirect target", {67'd0, br_right, br_addr}, {67'd0, e_rt, x});
        if (mem_chk) chk(tag, "memory word", {40'd0, mem[x[5:0]]}, {40'd0, e_word});
        m_ac = e_ac; m_mq = e_mq;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 40'(i * 3);
        mem[1] = 40'd25;
        mem[2] = -40'sd7;
        mem[3] = 40'd0;
        mem[4] = 40'h00_1234_5678;
        mem[5] = 40'h12_3456_789A;
        mem[6] = 40'h7F_FFFF_FFFF;
        mem[7] = -40'sd100;
        mem[8] = 40'd7;
        mem[9] = 40'h00_0000_0ABC;
        mem[11] = -40'sd1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "ready", {79'd0, ready}, 80'd1);
        chk("R1", "AC", {40'd0, ac_out}, 80'd0);
        chk("R1", "MQ", {40'd0, mq_out}, 80'd0);
        chk("R1", "pulses", {75'd0, done, illegal_op, div_zero, br_valid, mem_req}, 80'd0);

        run(8'h01, 12'd1, "R3 load");
        run(8'h02, 12'd2, "R3 load negated");
        run(8'h03, 12'd2, "R3 load abs");
        run(8'h04, 12'd1, "R3 load neg abs");
        run(8'h09, 12'd2, "R4 load MQ");
        run(8'h0A, 12'd0, "R4 MQ to AC");
        run(8'h21, 12'd10, "R4 store");
        run(8'h01, 12'd1, "R2 read timing");
        run(8'h05, 12'd2, "R5 add");
        run(8'h07, 12'd2, "R5 add abs");
        run(8'h06, 12'd2, "R5 subtract");
        run(8'h08, 12'd2, "R5 subtract abs");
        run(8'h14, 12'd0, "R9 shift left");
        run(8'h02, 12'd1, "R3 load negated");
        run(8'h15, 12'd0, "R9 shift right negative");
        run(8'h09, 12'd4, "R4 load MQ");
        run(8'h0B, 12'd2, "R6 multiply mixed sign");
        run(8'h09, 12'd6, "R4 load MQ");
        run(8'h0B, 12'd6, "R6 multiply large");
        run(8'h09, 12'd11, "R4 load MQ");
        run(8'h0B, 12'd11, "R6 multiply negatives");
        run(8'h01, 12'd7, "R3 load");
        run(8'h0C, 12'd8, "R7 divide negative dividend");
        run(8'h01, 12'd6, "R3 load");
        run(8'h0C, 12'd2, "R7 divide negative divisor");
        run(8'h0C, 12'd3, "R8 divide by zero");
        run(8'h0D, 12'd20, "R10 jump left");
        run(8'h0E, 12'd21, "R10 jump right");
        run(8'h01, 12'd1, "R3 load");
        run(8'h0F, 12'd30, "R11 conditional taken");
        run(8'h02, 12'd1, "R3 load negated");
        run(8'h10, 12'd31, "R11 conditional not taken");
        run(8'h0F, 12'd32, "R11 conditional left not taken");
        run(8'h01, 12'd3, "R3 load zero");
        run(8'h10, 12'd33, "R11 conditional taken at zero");
        run(8'h01, 12'd9, "R3 load");
        run(8'h12, 12'd5, "R12 patch left field");
        run(8'h13, 12'd5, "R12 patch right field");
        run(8'hFF, 12'd5, "R13 unknown opcode");
        run(8'h00, 12'd5, "R13 zero opcode");
        run(8'h11, 12'd5, "R13 gap opcode");
        summary();
        $finish;
    end
endmodule